// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Status

This block takes an asynchronous serial line and turns it into characters. The line is observed only when a base-rate enable from an external prescaler is high. Each sample passes through a two-sample agreement filter, which removes glitches that last one sample. A bit lasts sixteen enable ticks. The receiver confirms a start bit at its middle, then shifts in seven or eight data bits, least significant bit first. After the data it may check a parity bit, and it then checks the stop bit.

A finished character is written to a receive buffer and a buffer-full flag is set. A three-bit error status register collects parity, framing and overrun flags. Reading the buffer clears the full flag. Reading the status register clears every flag in it. Each character ends with exactly one one-cycle pulse. The pulse is on the receive-complete output when the character had no fault, and on a separate error interrupt output when it had one.

Top module: `uart_rx_flags`

## Requirements
- R1: After reset, rxData is 0, bufFull is 0, errStatus is 0, and neither rxDone nor rxErrIrq is high.
- R2: rxLine is sampled only in clock cycles where baseTick is 1. The filtered line takes a new value only when two consecutive samples agree, so a low level that lasts one tick is ignored and the internal view of the line lags by two ticks.
- R3: A start is accepted only when the filtered line is still low at the mid-bit point, 8 ticks after the falling edge is first seen. Otherwise the receiver returns to idle and produces no pulse.
- R4: Each bit lasts 16 ticks and is sampled at its middle. Data bits arrive least significant first. charLen8=1 selects 8 data bits. charLen8=0 selects 7 data bits, with rxData[7] forced to 0.
- R5: parityMode encodes the parity: 0 = no parity bit, 1 = even, 2 = odd, 3 = always zero. When a parity bit does not match the mode, errStatus[0] is set.
- R6: A stop bit sampled low sets errStatus[1].
- R7: If a character completes while bufFull is 1 and bufRead is low in that cycle, errStatus[2] is set. The new character overwrites rxData and bufFull stays 1.
- R8: In the cycle a character completes, rxData is loaded, bufFull becomes 1 and exactly one one-cycle pulse appears. The pulse is on rxErrIrq if that character raised any flag, and on rxDone otherwise.
- R9: Flags accumulate until a statRead pulse, which clears errStatus to 0. A flag raised in the same cycle as the read survives the read.
- R10: A bufRead pulse clears bufFull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Sample enable from the prescaler, 16 per bit |
| rxLine | input | 1 | Serial input line, idle high |
| charLen8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| parityMode | input | 2 | 0 none, 1 even, 2 odd, 3 always zero |
| bufRead | input | 1 | Read strobe for the receive buffer |
| statRead | input | 1 | Read strobe for the error status register |
| rxData | output | 8 | Receive buffer |
| bufFull | output | 1 | Buffer holds an unread character |
| errStatus | output | 3 | {overrun, framing, parity} flags |
| rxDone | output | 1 | One-cycle pulse for a character without errors |
| rxErrIrq | output | 1 | One-cycle pulse for a character with errors |

## Verification
Every 8-bit value is received with even parity and every 7-bit value with odd parity. A wrong bit order, a wrong length or a wrong parity sense therefore each show up as a data or flag mismatch on some value. Further frames without parity and with always-zero parity separate the four parity modes.

Deliberate faults test each flag on its own: a flipped parity bit, a shortened low stop bit, and two characters sent without reading the buffer. Another sequence shows that flags accumulate until the status register is read. One-tick glitches on the idle line and inside a data bit, together with a short false start, show that the filter and the mid-bit start check reject noise, while the frame that follows is still received intact.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rxState_t;

  typedef struct packed {
    logic shiftEn;
    logic parEn;
    logic finishEn;
  } rxCtl_t;

  localparam logic [1:0] PAR_NONE = 2'd0;
  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
  localparam logic [1:0] PAR_ZERO = 2'd3;
endpackage

// File: rtl/rx_control.sv
module rx_control
  import rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       filtLine,
  input  logic       charLen8,
  input  logic [1:0] parityMode,
  output rxCtl_t     ctl
);
  localparam int CW   = $clog2(TICKS_PER_BIT);
  localparam int BW   = $clog2(MAX_BITS + 1);
  localparam int HALF = TICKS_PER_BIT / 2;

  rxState_t        state;
  logic [CW-1:0]   tickCnt;
  logic [BW-1:0]   bitCnt;
  logic [BW-1:0]   lastBit;
  logic            bitEnd;
  logic            midStart;

  assign lastBit  = charLen8 ? BW'(MAX_BITS - 1) : BW'(MAX_BITS - 2);
  assign bitEnd   = baseTick && (tickCnt == CW'(TICKS_PER_BIT - 1));
  assign midStart = baseTick && (tickCnt == CW'(HALF - 1));

  always_comb begin
    ctl          = '0;
    ctl.shiftEn  = (state == ST_DATA) && bitEnd;
    ctl.parEn    = (state == ST_PAR)  && bitEnd;
    ctl.finishEn = (state == ST_STOP) && bitEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (baseTick && !filtLine) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (midStart) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= filtLine ? ST_IDLE : ST_DATA;
          end else if (baseTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: begin
          if (bitEnd) begin
            tickCnt <= '0;
            case (state)
              ST_DATA: begin
                if (bitCnt == lastBit)
                  state <= (parityMode != PAR_NONE) ? ST_PAR : ST_STOP;
                else
                  bitCnt <= bitCnt + 1'b1;
              end
              ST_PAR:  state <= ST_STOP;
              default: state <= ST_IDLE;
            endcase
          end else if (baseTick) begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int MAX_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baseTick,
  input  logic                rxLine,
  input  rxCtl_t              ctl,
  input  logic                charLen8,
  input  logic [1:0]          parityMode,
  input  logic                bufRead,
  input  logic                statRead,
  output logic                filtLine,
  output logic [MAX_BITS-1:0] rxData,
  output logic                bufFull,
  output logic [2:0]          errStatus,
  output logic                rxDone,
  output logic                rxErrIrq
);
  logic                sampReg;
  logic [MAX_BITS-1:0] shiftReg;
  logic                parBit;
  logic [MAX_BITS-1:0] frameData;
  logic                expPar;
  logic [2:0]          newFlags;

  // Two-sample agreement filter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampReg  <= 1'b1;
      filtLine <= 1'b1;
    end else if (baseTick) begin
      sampReg <= rxLine;
      if (rxLine == sampReg) filtLine <= rxLine;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (ctl.shiftEn) shiftReg <= {filtLine, shiftReg[MAX_BITS-1:1]};
      if (ctl.parEn)   parBit   <= filtLine;
    end
  end

  assign frameData = charLen8 ? shiftReg : {1'b0, shiftReg[MAX_BITS-1:1]};

  always_comb begin
    case (parityMode)
      PAR_EVEN: expPar = ^frameData;
      PAR_ODD:  expPar = ~^frameData;
      default:  expPar = 1'b0;
    endcase
    newFlags = '0;
    if (ctl.finishEn) begin
      newFlags[0] = (parityMode != PAR_NONE) && (parBit != expPar);
      newFlags[1] = !filtLine;
      newFlags[2] = bufFull && !bufRead;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData    <= '0;
      bufFull   <= 1'b0;
      errStatus <= '0;
      rxDone    <= 1'b0;
      rxErrIrq  <= 1'b0;
    end else begin
      errStatus <= (statRead ? 3'b000 : errStatus) | newFlags;
      rxDone    <= ctl.finishEn && (newFlags == 3'b000);
      rxErrIrq  <= ctl.finishEn && (newFlags != 3'b000);
      if (ctl.finishEn) begin
        rxData  <= frameData;
        bufFull <= 1'b1;
      end else if (bufRead) begin
        bufFull <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import rx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int MAX_BITS      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baseTick,
  input  logic                rxLine,
  input  logic                charLen8,
  input  logic [1:0]          parityMode,
  input  logic                bufRead,
  input  logic                statRead,
  output logic [MAX_BITS-1:0] rxData,
  output logic                bufFull,
  output logic [2:0]          errStatus,
  output logic                rxDone,
  output logic                rxErrIrq
);
  rxCtl_t ctl;
  logic   filtLine;

  rx_control #(.TICKS_PER_BIT(TICKS_PER_BIT), .MAX_BITS(MAX_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .filtLine(filtLine),
    .charLen8(charLen8), .parityMode(parityMode), .ctl(ctl)
  );

  rx_datapath #(.MAX_BITS(MAX_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .rxLine(rxLine), .ctl(ctl),
    .charLen8(charLen8), .parityMode(parityMode), .bufRead(bufRead),
    .statRead(statRead), .filtLine(filtLine), .rxData(rxData),
    .bufFull(bufFull), .errStatus(errStatus), .rxDone(rxDone),
    .rxErrIrq(rxErrIrq)
  );
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk (
  input logic       clk,
  input logic       rstN,
  input logic       baseTick,
  input logic       rxLine,
  input logic       filtLine,
  input logic       bufRead,
  input logic       statRead,
  input logic       bufFull,
  input logic [2:0] errStatus,
  input logic       rxDone,
  input logic       rxErrIrq
);
  // R2
  filt_follows_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (filtLine != $past(filtLine)) |-> ($past(baseTick) && ($past(rxLine) == filtLine)));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxDone && rxErrIrq));

  // R8
  pulse_sets_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone || rxErrIrq) |-> bufFull);

  // R8
  err_pulse_has_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxErrIrq |-> (errStatus != 3'b000));

  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statRead |=> ((errStatus == 3'b000) || rxErrIrq));

  // R7
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((rxDone || rxErrIrq) && $past(bufFull) && !$past(bufRead)) |-> errStatus[2]);

  // R10
  read_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && !rxDone && !rxErrIrq) |=> (!bufFull || rxDone || rxErrIrq));
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk(clk), .rstN(rstN), .baseTick(baseTick), .rxLine(rxLine),
  .filtLine(filtLine), .bufRead(bufRead), .statRead(statRead),
  .bufFull(bufFull), .errStatus(errStatus), .rxDone(rxDone),
  .rxErrIrq(rxErrIrq)
);

// File: tb/tb_uart_rx_flags.sv
module tb_uart_rx_flags;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b0;
  logic       rxLine = 1'b1;
  logic       charLen8 = 1'b1;
  logic [1:0] parityMode = 2'd0;
  logic       bufRead = 1'b0;
  logic       statRead = 1'b0;
  logic [7:0] rxData;
  logic       bufFull;
  logic [2:0] errStatus;
  logic       rxDone;
  logic       rxErrIrq;

  int nChecks = 0;
  int nFails = 0;
  int tickDiv = 1;
  int tickPh = 0;
  int evDone = 0;
  int evErr = 0;
  logic [7:0] evData = '0;
  logic [2:0] evStat = '0;
  bit finished = 0;

  uart_rx_flags dut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .rxLine(rxLine),
    .charLen8(charLen8), .parityMode(parityMode), .bufRead(bufRead),
    .statRead(statRead), .rxData(rxData), .bufFull(bufFull),
    .errStatus(errStatus), .rxDone(rxDone), .rxErrIrq(rxErrIrq)
  );

  always #4 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      tickPh   = (tickPh + 1) % tickDiv;
      baseTick = (tickPh == 0);
    end
  end

  always @(negedge clk) begin
    if (rxDone)   begin evDone++; evData = rxData; evStat = errStatus; end
    if (rxErrIrq) begin evErr++;  evData = rxData; evStat = errStatus; end
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic holdTicks(input logic v, input int n);
    rxLine = v;
    repeat (n * tickDiv) @(negedge clk);
  endtask

  function automatic logic parFor(input logic [7:0] d, input logic [1:0] m);
    case (m)
      2'd1: return ($countones(d) % 2) == 1;
      2'd2: return ($countones(d) % 2) == 0;
      default: return 1'b0;
    endcase
  endfunction

  // glitchBit: data bit index carrying a one-tick low glitch, -1 for none
  task automatic sendChar(input logic [7:0] d, input logic len8, input logic [1:0] m,
                          input bit flipPar, input int stopLow, input int glitchBit);
    int nb;
    logic [7:0] dm;
    nb = len8 ? 8 : 7;
    dm = len8 ? d : {1'b0, d[6:0]};
    charLen8 = len8;
    parityMode = m;
    holdTicks(1'b0, 16);
    for (int i = 0; i < nb; i++) begin
      if (i == glitchBit && dm[i]) begin
        holdTicks(1'b1, 7);
        holdTicks(1'b0, 1);
        holdTicks(1'b1, 8);
      end else begin
        holdTicks(dm[i], 16);
      end
    end
    if (m != 2'd0) holdTicks(parFor(dm, m) ^ flipPar, 16);
    if (stopLow > 0) holdTicks(1'b0, stopLow);
    holdTicks(1'b1, 16 - stopLow);
    holdTicks(1'b1, 32);
  endtask

  task automatic clearEv();
    evDone = 0; evErr = 0;
  endtask

  task automatic readRegs(input bit rdBuf, input bit rdStat);
    bufRead = rdBuf; statRead = rdStat;
    @(negedge clk);
    bufRead = 1'b0; statRead = 1'b0;
  endtask

  task automatic expectFrame(input string tag, input logic [7:0] expData,
                             input logic [2:0] expStat);
    check({tag, " done pulses"}, evDone, (expStat == 0) ? 1 : 0);
    check({tag, " error pulses"}, evErr, (expStat == 0) ? 0 : 1);
    check({tag, " data"}, evData, expData);
    check({tag, " status"}, evStat, expStat);
    check({tag, " bufFull"}, bufFull, 1);
  endtask

  task automatic readAndClear(input string tag);
    readRegs(1'b1, 1'b1);
    check({tag, " R10 bufFull cleared"}, bufFull, 0);
    check({tag, " R9 status cleared"}, errStatus, 0);
    clearEv();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset rxData", rxData, 0);
    check("R1 reset bufFull", bufFull, 0);
    check("R1 reset errStatus", errStatus, 0);
    check("R1 reset pulses", {rxDone, rxErrIrq}, 0);
    holdTicks(1'b1, 8);

    // R4 R5 R8: all 8-bit values, even parity
    for (int v = 0; v < 256; v++) begin
      sendChar(8'(v), 1'b1, 2'd1, 0, 0, -1);
      expectFrame("R4 R5 R8 8bit even", 8'(v), 3'b000);
      readAndClear("R4 8bit even");
    end
    // R4 R5: all 7-bit values, odd parity
    for (int v = 0; v < 128; v++) begin
      sendChar(8'(v) | 8'h80, 1'b0, 2'd2, 0, 0, -1);
      expectFrame("R4 R5 7bit odd", 8'(v), 3'b000);
      readAndClear("R4 7bit odd");
    end

    tickDiv = 2;
    holdTicks(1'b1, 8);
    // R5 no parity and always-zero parity
    sendChar(8'hA5, 1'b1, 2'd0, 0, 0, -1);
    expectFrame("R5 none", 8'hA5, 3'b000);
    readAndClear("R5 none");
    sendChar(8'h5B, 1'b1, 2'd3, 0, 0, -1);
    expectFrame("R5 zero", 8'h5B, 3'b000);
    readAndClear("R5 zero");
    sendChar(8'h5B, 1'b1, 2'd3, 1, 0, -1);
    expectFrame("R5 zero mismatch", 8'h5B, 3'b001);
    readAndClear("R5 zero mismatch");
    sendChar(8'h3C, 1'b1, 2'd2, 1, 0, -1);
    expectFrame("R5 odd mismatch", 8'h3C, 3'b001);
    readAndClear("R5 odd mismatch");

    // R6 framing
    sendChar(8'h81, 1'b1, 2'd0, 0, 12, -1);
    expectFrame("R6 framing", 8'h81, 3'b010);
    readAndClear("R6 framing");

    // R7 overrun: two characters, buffer never read
    sendChar(8'h11, 1'b1, 2'd0, 0, 0, -1);
    clearEv();
    sendChar(8'h22, 1'b1, 2'd0, 0, 0, -1);
    expectFrame("R7 overrun", 8'h22, 3'b100);
    readAndClear("R7 overrun");

    // R9 accumulation: parity flag, buffer read only, then framing flag
    sendChar(8'h0F, 1'b1, 2'd1, 1, 0, -1);
    readRegs(1'b1, 1'b0);
    check("R10 bufRead alone clears bufFull", bufFull, 0);
    check("R9 flag kept without statRead", errStatus, 3'b001);
    clearEv();
    sendChar(8'hF0, 1'b1, 2'd1, 0, 12, -1);
    expectFrame("R9 accumulate", 8'hF0, 3'b011);
    readAndClear("R9 accumulate");

    // R3 false start and R2 idle glitch produce no character
    holdTicks(1'b0, 4);
    holdTicks(1'b1, 48);
    check("R3 short start no pulse", evDone + evErr, 0);
    holdTicks(1'b0, 1);
    holdTicks(1'b1, 48);
    check("R2 idle glitch no pulse", evDone + evErr, 0);
    check("R3 bufFull still clear", bufFull, 0);

    // R2 one-tick glitch inside a data bit
    sendChar(8'hFF, 1'b1, 2'd1, 0, 0, 3);
    expectFrame("R2 data glitch", 8'hFF, 3'b000);
    readAndClear("R2 data glitch");

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule